// File: doc/BRIEF.md
# Group Power Sequencer with PCM Bypass

This block controls the power state of a set of processing groups in a multi-channel TDM voice device. Each group serves two channels (an even "A" channel and an odd "B" channel) and has one main control byte. Bit 0 of that byte is the group's power-up bit. Software writes it through a byte-wide register port on an 11-bit address bus. The same port reaches the per-channel control bytes, a test register and an interrupt status register. Power-up is refused until the clock generator reports lock.

When a group's power-up bit goes from 0 to 1, the block starts that group's initialization. It restores the group's 64 per-channel bytes to their defaults, sends one coefficient-clear pulse to the processing core, and holds an init-busy flag while a fixed number of frames pass. Frame boundaries are the rising edges of the frame-sync input. While a group is powered down, both of its PCM streams (receive and send) skip the core. They pass through a per-timeslot buffer two frames deep, so a bypassed sample leaves in the same timeslot two frames after it arrived.

Top module: `pwr_bypass_ctrl`

## Requirements
- R1: While rst_n is low, every main control byte and the test register are zero. out_en, init_busy, coef_clear, out_valid, rout_data, sout_data and rd_data are all zero. After rst_n rises, out_en goes high within four clock cycles.
- R2: While pll_locked is low, a write to a main control byte leaves bit 0 unchanged. Bits 7:1 are still stored, so writing 0x81 to a cleared byte reads back as 0x80 and no initialization starts.
- R3: Main control bytes sit at 0x400+g for group g. All eight bits are stored and read back, and only bit 0 has any effect. The test register at 0x411 is read/write. Address 0x410 (interrupt status) always reads zero.
- R4: On the clock edge after a group's power-up bit changes from 0 to 1, init_busy[g] rises and coef_clear[g] is high for exactly one cycle.
- R5: When an initialization starts, the group's 64 bytes (addresses whose bits 9:6 equal g) are reloaded. The byte at channel offset 0 (address bits 4:0 equal zero) becomes 0x01 and every other byte becomes 0x00. Other groups' bytes are unchanged. The same values are loaded at reset.
- R6: init_busy stays high through the first frame boundary after the power-up edge and through one more. It clears on the edge that detects the third boundary, so two complete frames are counted.
- R7: A per-channel write to a group whose init_busy is high is dropped. A per-channel write to a group that is not busy is stored.
- R8: Writing 0 to the power-up bit powers the group down. If an initialization is running, init_busy clears one cycle after the write takes effect.
- R9: Timeslot s belongs to group s/2. When that group's power-up bit is 0, rout_data and sout_data carry the rin_data and sin_data samples given in slot s two slot-s samples earlier. Before that history exists the outputs are zero. When the bit is 1, they carry core_rout and core_sout.
- R10: out_valid and out_slot repeat pcm_valid and pcm_slot with one cycle of delay, and the data outputs are updated in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | Clock generator lock indication |
| frame_sync | input | 1 | Frame pulse; rising edge marks a boundary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 11 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 11 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| init_busy | output | 16 | Per-group initialization in progress |
| coef_clear | output | 16 | Per-group one-cycle coefficient clear request |
| pcm_valid | input | 1 | A PCM sample pair is present |
| pcm_slot | input | 5 | Timeslot of the present sample pair |
| rin_data | input | 8 | Receive-side input sample |
| sin_data | input | 8 | Send-side input sample |
| core_rout | input | 8 | Core receive-side result for the present slot |
| core_sout | input | 8 | Core send-side result for the present slot |
| out_en | output | 1 | Outputs active (low during reset) |
| out_valid | output | 1 | Output sample pair present |
| out_slot | output | 5 | Timeslot of the output pair |
| rout_data | output | 8 | Receive-side output sample |
| sout_data | output | 8 | Send-side output sample |

## Verification
The bench tries a power-up request while lock is missing. A design that gates the whole write instead of only bit 0 loses bits 7:1, and a design that does not gate at all starts an initialization. It counts frame pulses one by one after a power-up edge: an off-by-one in the frame counter shows up as init_busy clearing one boundary early or late. It writes per-channel bytes during and after initialization, and reads back a neighbouring group's byte to catch defaults loaded over the wrong group. Random slot streams with idle gaps run while the per-group power pattern changes. A bypass buffer that is one stage too short, that keys on arrival order instead of timeslot, or that maps slots to the wrong group gives a wrong sample in some slot.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_WAIT  = 2'd1,
    GS_COUNT = 2'd2
  } grp_state_e;

endpackage

// File: rtl/pbc_main_regs.sv
module pbc_main_regs #(
  parameter int NUM_GROUPS = 16,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 11,
  parameter int MAIN_BASE  = 1024,
  parameter int TEST_ADDR  = 1041
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                pll_locked,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_GROUPS-1:0][DATA_W-1:0]   main_q,
  output logic [DATA_W-1:0]                   test_q
);

  logic [NUM_GROUPS-1:0][DATA_W-1:0] main_d;
  logic [DATA_W-1:0]                 test_d;

  always_comb begin
    main_d = main_q;
    test_d = test_q;
    if (wr_en) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (wr_addr == ADDR_W'(MAIN_BASE + g)) begin
          main_d[g][DATA_W-1:1] = wr_data[DATA_W-1:1];
          // the power-up bit only moves once the clock source is locked
          if (pll_locked) begin
            main_d[g][0] = wr_data[0];
          end
        end
      end
      if (wr_addr == ADDR_W'(TEST_ADDR)) begin
        test_d = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      test_q <= '0;
    end else if (wr_en) begin
      main_q <= main_d;
      test_q <= test_d;
    end
  end

endmodule

// File: rtl/pbc_group_seq.sv
module pbc_group_seq
  import pbc_pkg::*;
#(
  parameter int INIT_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwup,
  input  logic frame_edge,
  output logic init_busy,
  output logic coef_clear,
  output logic load_defaults
);

  localparam int CNT_W = $clog2(INIT_FRAMES + 1);

  grp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pwup_q;
  logic             clr_q;
  logic             rise;

  assign rise          = pwup & ~pwup_q;
  assign load_defaults = rise;
  assign init_busy     = (state_q != GS_IDLE);
  assign coef_clear    = clr_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!pwup) begin
      state_d = GS_IDLE;
      cnt_d   = '0;
    end else if (rise) begin
      state_d = GS_WAIT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        GS_WAIT: begin
          if (frame_edge) begin
            state_d = GS_COUNT;
            cnt_d   = '0;
          end
        end
        GS_COUNT: begin
          if (frame_edge) begin
            if (cnt_q == CNT_W'(INIT_FRAMES - 1)) begin
              state_d = GS_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          state_d = GS_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      cnt_q   <= '0;
      pwup_q  <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pwup_q  <= pwup;
      clr_q   <= rise;
    end
  end

endmodule

// File: rtl/pbc_chan_regs.sv
module pbc_chan_regs #(
  parameter int NUM_GROUPS   = 16,
  parameter int CH_PER_GROUP = 2,
  parameter int REG_BYTES    = 32,
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_GROUPS-1:0] grp_busy,
  input  logic [NUM_GROUPS-1:0] grp_load,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data
);

  localparam int GRP_BYTES = CH_PER_GROUP * REG_BYTES;
  localparam int DEPTH     = NUM_GROUPS * GRP_BYTES;
  localparam int CH_AW     = $clog2(DEPTH);
  localparam int GRP_LSB   = $clog2(GRP_BYTES);
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;
  logic [GRP_W-1:0]             wr_grp;
  logic                         wr_hit;

  function automatic logic [DATA_W-1:0] dflt_byte(input int idx);
    return ((idx % REG_BYTES) == 0) ? DATA_W'(1) : '0;
  endfunction

  assign wr_grp = GRP_W'(wr_addr[CH_AW-1:GRP_LSB]);
  assign wr_hit = wr_en && (wr_addr < ADDR_W'(DEPTH)) &&
                  !grp_busy[wr_grp] && !grp_load[wr_grp];

  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (grp_load[i / GRP_BYTES]) begin
        mem_d[i] = dflt_byte(i);
      end
    end
    if (wr_hit) begin
      mem_d[wr_addr[CH_AW-1:0]] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= dflt_byte(i);
      end
    end else begin
      mem_q <= mem_d;
    end
  end

  assign rd_data = mem_q[rd_addr[CH_AW-1:0]];

endmodule

// File: rtl/pbc_pcm_bypass.sv
module pbc_pcm_bypass #(
  parameter int NUM_GROUPS   = 16,
  parameter int CH_PER_GROUP = 2,
  parameter int PCM_W        = 8,
  parameter int DELAY_FRAMES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [$clog2(NUM_GROUPS*CH_PER_GROUP)-1:0] in_slot,
  input  logic [PCM_W-1:0]              rin,
  input  logic [PCM_W-1:0]              sin,
  input  logic [PCM_W-1:0]              core_rout,
  input  logic [PCM_W-1:0]              core_sout,
  input  logic [NUM_GROUPS-1:0]         grp_power,
  output logic                          out_valid,
  output logic [$clog2(NUM_GROUPS*CH_PER_GROUP)-1:0] out_slot,
  output logic [PCM_W-1:0]              rout,
  output logic [PCM_W-1:0]              sout
);

  localparam int NUM_CH = NUM_GROUPS * CH_PER_GROUP;
  localparam int SLOT_W = $clog2(NUM_CH);
  localparam int CPG_W  = $clog2(CH_PER_GROUP);
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  logic [DELAY_FRAMES-1:0][NUM_CH-1:0][PCM_W-1:0] rbuf_q, rbuf_d;
  logic [DELAY_FRAMES-1:0][NUM_CH-1:0][PCM_W-1:0] sbuf_q, sbuf_d;
  logic [GRP_W-1:0] in_grp;
  logic             bypass;
  logic [PCM_W-1:0] rout_d, sout_d;

  assign in_grp = GRP_W'(in_slot >> CPG_W);
  assign bypass = !grp_power[in_grp];

  // per-slot shift: stage 0 takes the new sample, the last stage is the oldest
  always_comb begin
    rbuf_d = rbuf_q;
    sbuf_d = sbuf_q;
    if (in_valid) begin
      for (int k = 0; k < DELAY_FRAMES; k++) begin
        if (k == 0) begin
          rbuf_d[k][in_slot] = rin;
          sbuf_d[k][in_slot] = sin;
        end else begin
          rbuf_d[k][in_slot] = rbuf_q[k-1][in_slot];
          sbuf_d[k][in_slot] = sbuf_q[k-1][in_slot];
        end
      end
    end
  end

  always_comb begin
    rout_d = bypass ? rbuf_q[DELAY_FRAMES-1][in_slot] : core_rout;
    sout_d = bypass ? sbuf_q[DELAY_FRAMES-1][in_slot] : core_sout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      sbuf_q <= '0;
    end else if (in_valid) begin
      rbuf_q <= rbuf_d;
      sbuf_q <= sbuf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_slot  <= '0;
      rout      <= '0;
      sout      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_slot <= SLOT_W'(in_slot);
        rout     <= rout_d;
        sout     <= sout_d;
      end
    end
  end

endmodule

// File: rtl/pwr_bypass_ctrl.sv
module pwr_bypass_ctrl #(
  parameter int NUM_GROUPS   = 16,
  parameter int CH_PER_GROUP = 2,
  parameter int REG_BYTES    = 32,
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 11,
  parameter int PCM_W        = 8,
  parameter int INIT_FRAMES  = 2,
  parameter int DELAY_FRAMES = 2,
  localparam int SLOT_W      = $clog2(NUM_GROUPS * CH_PER_GROUP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pll_locked,
  input  logic                  frame_sync,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_GROUPS-1:0] init_busy,
  output logic [NUM_GROUPS-1:0] coef_clear,
  input  logic                  pcm_valid,
  input  logic [SLOT_W-1:0]     pcm_slot,
  input  logic [PCM_W-1:0]      rin_data,
  input  logic [PCM_W-1:0]      sin_data,
  input  logic [PCM_W-1:0]      core_rout,
  input  logic [PCM_W-1:0]      core_sout,
  output logic                  out_en,
  output logic                  out_valid,
  output logic [SLOT_W-1:0]     out_slot,
  output logic [PCM_W-1:0]      rout_data,
  output logic [PCM_W-1:0]      sout_data
);

  localparam int CH_SPACE  = NUM_GROUPS * CH_PER_GROUP * REG_BYTES;
  localparam int MAIN_BASE = CH_SPACE;
  localparam int IRQ_ADDR  = MAIN_BASE + NUM_GROUPS;
  localparam int TEST_ADDR = IRQ_ADDR + 1;

  logic [1:0]                        rst_sync_q;
  logic                              rst_int_n;
  logic                              out_en_q;
  logic                              fs_q;
  logic                              frame_edge;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] main_q;
  logic [DATA_W-1:0]                 test_q;
  logic [NUM_GROUPS-1:0]             pwup_bits;
  logic [NUM_GROUPS-1:0]             load_dflt;
  logic [DATA_W-1:0]                 chan_rd;
  logic [DATA_W-1:0]                 rd_mux;

  // reset: asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_en_q <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      out_en_q <= 1'b1;
      fs_q     <= frame_sync;
    end
  end
  assign out_en     = out_en_q;
  assign frame_edge = frame_sync & ~fs_q;

  pbc_main_regs #(
    .NUM_GROUPS (NUM_GROUPS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .MAIN_BASE  (MAIN_BASE),
    .TEST_ADDR  (TEST_ADDR)
  ) u_main (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pll_locked (pll_locked),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .main_q     (main_q),
    .test_q     (test_q)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign pwup_bits[g] = main_q[g][0];
    pbc_group_seq #(
      .INIT_FRAMES (INIT_FRAMES)
    ) u_seq (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .pwup          (pwup_bits[g]),
      .frame_edge    (frame_edge),
      .init_busy     (init_busy[g]),
      .coef_clear    (coef_clear[g]),
      .load_defaults (load_dflt[g])
    );
  end

  pbc_chan_regs #(
    .NUM_GROUPS   (NUM_GROUPS),
    .CH_PER_GROUP (CH_PER_GROUP),
    .REG_BYTES    (REG_BYTES),
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W)
  ) u_chan (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .grp_busy (init_busy),
    .grp_load (load_dflt),
    .rd_addr  (rd_addr),
    .rd_data  (chan_rd)
  );

  pbc_pcm_bypass #(
    .NUM_GROUPS   (NUM_GROUPS),
    .CH_PER_GROUP (CH_PER_GROUP),
    .PCM_W        (PCM_W),
    .DELAY_FRAMES (DELAY_FRAMES)
  ) u_byp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (pcm_valid),
    .in_slot   (pcm_slot),
    .rin       (rin_data),
    .sin       (sin_data),
    .core_rout (core_rout),
    .core_sout (core_sout),
    .grp_power (pwup_bits),
    .out_valid (out_valid),
    .out_slot  (out_slot),
    .rout      (rout_data),
    .sout      (sout_data)
  );

  // read decode; the interrupt status byte has no source and reads zero
  always_comb begin
    rd_mux = '0;
    if (rd_addr < ADDR_W'(CH_SPACE)) begin
      rd_mux = chan_rd;
    end else if (rd_addr == ADDR_W'(TEST_ADDR)) begin
      rd_mux = test_q;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (rd_addr == ADDR_W'(MAIN_BASE + g)) begin
          rd_mux = main_q[g];
        end
      end
    end
  end
  assign rd_data = out_en_q ? rd_mux : '0;

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker #(
  parameter int NUM_GROUPS = 16,
  parameter int ADDR_W     = 11,
  parameter int SLOT_W     = 5,
  parameter int MAIN_BASE  = 1024
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pll_locked,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [NUM_GROUPS-1:0] pwup_bits,
  input logic [NUM_GROUPS-1:0] init_busy,
  input logic [NUM_GROUPS-1:0] coef_clear,
  input logic                  pcm_valid,
  input logic [SLOT_W-1:0]     pcm_slot,
  input logic                  out_valid,
  input logic [SLOT_W-1:0]     out_slot,
  input logic                  out_en
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (pwup_bits == '0 && init_busy == '0 &&
                                coef_clear == '0 && !out_en && !out_valid);
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    a_r4_rise_starts_init: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwup_bits[g]) |=> (init_busy[g] && coef_clear[g]));

    a_r4_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
      coef_clear[g] |=> !coef_clear[g]);

    a_r8_down_idles: assert property (@(posedge clk) disable iff (!rst_n)
      !pwup_bits[g] |=> !init_busy[g]);

    a_r2_pll_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_locked && wr_en && wr_addr == ADDR_W'(MAIN_BASE + g))
        |=> $stable(pwup_bits[g]));
  end

  a_r10_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |=> !out_valid);

  a_r10_slot_follow: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> (out_valid && out_slot == $past(pcm_slot)));

endmodule

bind pwr_bypass_ctrl pbc_checker #(
  .NUM_GROUPS (NUM_GROUPS),
  .ADDR_W     (ADDR_W),
  .SLOT_W     (SLOT_W),
  .MAIN_BASE  (MAIN_BASE)
) u_pbc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_locked (pll_locked),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .pwup_bits  (pwup_bits),
  .init_busy  (init_busy),
  .coef_clear (coef_clear),
  .pcm_valid  (pcm_valid),
  .pcm_slot   (pcm_slot),
  .out_valid  (out_valid),
  .out_slot   (out_slot),
  .out_en     (out_en)
);

// File: tb/test_pwr_bypass_ctrl.sv
`timescale 1ns/1ps
module test_pwr_bypass_ctrl;

  localparam int NG = 16;
  localparam int NC = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pll_locked;
  logic          frame_sync;
  logic          wr_en;
  logic [10:0]   wr_addr;
  logic [7:0]    wr_data;
  logic [10:0]   rd_addr;
  logic [7:0]    rd_data;
  logic [NG-1:0] init_busy;
  logic [NG-1:0] coef_clear;
  logic          pcm_valid;
  logic [4:0]    pcm_slot;
  logic [7:0]    rin_data, sin_data, core_rout, core_sout;
  logic          out_en, out_valid;
  logic [4:0]    out_slot;
  logic [7:0]    rout_data, sout_data;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  logic [7:0] h1r [NC];
  logic [7:0] h2r [NC];
  logic [7:0] h1s [NC];
  logic [7:0] h2s [NC];
  logic [NG-1:0] pwr_model;

  always #5 clk = ~clk;

  pwr_bypass_ctrl i_pwr_bypass_ctrl (
    .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .frame_sync(frame_sync),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .init_busy(init_busy), .coef_clear(coef_clear),
    .pcm_valid(pcm_valid), .pcm_slot(pcm_slot),
    .rin_data(rin_data), .sin_data(sin_data),
    .core_rout(core_rout), .core_sout(core_sout),
    .out_en(out_en), .out_valid(out_valid), .out_slot(out_slot),
    .rout_data(rout_data), .sout_data(sout_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [10:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic frame_pulse();
    @(negedge clk) frame_sync = 1'b1;
    @(negedge clk) frame_sync = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] dflt(input int a);
    return ((a % 32) == 0) ? 8'h01 : 8'h00;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; pll_locked = 1'b0; frame_sync = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    pcm_valid = 1'b0; pcm_slot = '0; rin_data = '0; sin_data = '0;
    core_rout = '0; core_sout = '0;
    for (int s = 0; s < NC; s++) begin
      h1r[s] = '0; h2r[s] = '0; h1s[s] = '0; h2s[s] = '0;
    end

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    chk(out_en == 1'b0, "R1 out_en", out_en, 0);
    chk(init_busy == '0 && coef_clear == '0, "R1 busy/clear", {init_busy, coef_clear}, 0);
    chk(out_valid == 1'b0 && rout_data == '0 && sout_data == '0, "R1 pcm outputs",
        {out_valid, rout_data, sout_data}, 0);
    reg_rd(11'h400, d); chk(d == 8'h00, "R1 main reg read", d, 0);
    reg_rd(11'h411, d); chk(d == 8'h00, "R1 test reg read", d, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_en == 1'b1, "R1 out_en after release", out_en, 1);
    for (int g = 0; g < NG; g++) begin
      reg_rd(11'(11'h400 + g), d);
      chk(d == 8'h00, "R1 main reg cleared", d, 0);
    end

    // R3: test and interrupt status registers
    reg_wr(11'h411, 8'hA5);
    reg_rd(11'h411, d); chk(d == 8'hA5, "R3 test reg rw", d, 8'hA5);
    reg_wr(11'h410, 8'h3C);
    reg_rd(11'h410, d); chk(d == 8'h00, "R3 irq reads zero", d, 0);

    // R2: power-up refused without lock, upper bits kept
    reg_wr(11'h403, 8'h81);
    reg_rd(11'h403, d); chk(d == 8'h80, "R2 pll gate bit0", d, 8'h80);
    repeat (2) @(negedge clk);
    chk(init_busy[3] == 1'b0, "R2 no init without lock", init_busy[3], 0);
    pll_locked = 1'b1;

    // R5/R7: default values and writes to idle groups
    reg_rd(11'h0C0, d); chk(d == dflt(11'h0C0), "R5 reset default", d, 1);
    reg_wr(11'h0C5, 8'h5A);
    reg_rd(11'h0C5, d); chk(d == 8'h5A, "R7 idle write kept", d, 8'h5A);
    reg_wr(11'h0E0, 8'hEE);
    reg_wr(11'h105, 8'h33);

    // R4: power-up edge of group 3
    reg_wr(11'h403, 8'h81);
    @(negedge clk);
    chk(init_busy[3] == 1'b1, "R4 busy rises", init_busy[3], 1);
    chk(coef_clear == 16'h0008, "R4 clear pulse", coef_clear, 16'h0008);
    @(negedge clk);
    chk(coef_clear == '0, "R4 clear one cycle", coef_clear, 0);
    reg_rd(11'h403, d); chk(d == 8'h81, "R3 main reg readback", d, 8'h81);

    // R5: group 3 reloaded, group 4 untouched
    reg_rd(11'h0C5, d); chk(d == 8'h00, "R5 default restored", d, 0);
    reg_rd(11'h0E0, d); chk(d == 8'h01, "R5 canceller B offset0", d, 1);
    reg_rd(11'h105, d); chk(d == 8'h33, "R5 other group kept", d, 8'h33);

    // R7: write while busy dropped
    reg_wr(11'h0C5, 8'h77);
    reg_rd(11'h0C5, d); chk(d == 8'h00, "R7 busy write dropped", d, 0);

    // R6: busy spans the boundary after the edge and two full frames
    frame_pulse();
    chk(init_busy[3] == 1'b1, "R6 busy after boundary 1", init_busy[3], 1);
    frame_pulse();
    chk(init_busy[3] == 1'b1, "R6 busy after boundary 2", init_busy[3], 1);
    frame_pulse();
    chk(init_busy[3] == 1'b0, "R6 done after boundary 3", init_busy[3], 0);
    reg_wr(11'h0C5, 8'h77);
    reg_rd(11'h0C5, d); chk(d == 8'h77, "R7 write after init", d, 8'h77);

    // R8: power-down aborts a running init
    reg_wr(11'h405, 8'h01);
    frame_pulse();
    chk(init_busy[5] == 1'b1, "R8 busy before abort", init_busy[5], 1);
    reg_wr(11'h405, 8'h00);
    @(negedge clk);
    chk(init_busy[5] == 1'b0, "R8 abort clears busy", init_busy[5], 0);

    // R9/R10: random slot streams with a changing power pattern
    for (int f = 0; f < 8; f++) begin
      pwr_model = NG'($urandom);
      if (f < 2) pwr_model = '0;
      for (int g = 0; g < NG; g++) begin
        reg_wr(11'(11'h400 + g), {7'h00, pwr_model[g]});
      end
      for (int s = 0; s < NC; s++) begin
        logic [7:0] er, es, rv, sv, cr, cs;
        if (($urandom % 4) == 0) begin
          pcm_valid = 1'b0;
          @(negedge clk);
          chk(out_valid == 1'b0, "R10 idle gap", out_valid, 0);
        end
        rv = 8'($urandom); sv = 8'($urandom);
        cr = 8'($urandom); cs = 8'($urandom);
        pcm_valid = 1'b1; pcm_slot = 5'(s);
        rin_data = rv; sin_data = sv; core_rout = cr; core_sout = cs;
        er = pwr_model[s / 2] ? cr : h2r[s];
        es = pwr_model[s / 2] ? cs : h2s[s];
        h2r[s] = h1r[s]; h1r[s] = rv;
        h2s[s] = h1s[s]; h1s[s] = sv;
        @(negedge clk);
        pcm_valid = 1'b0;
        chk(out_valid == 1'b1 && out_slot == 5'(s), "R10 valid/slot",
            {out_valid, out_slot}, {1'b1, 5'(s)});
        chk(rout_data == er && sout_data == es, "R9 sample path",
            {rout_data, sout_data}, {er, es});
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule